// File: doc/BRIEF.md
# Successive Masking Multi-Point Encoder

This block turns a two-dimensional plane of one-bit flags into a stream of coordinates, one flagged point per clock cycle. Each flag marks a detected object centroid. An ordinary priority encoder can name only one set bit at a time. The block therefore keeps a working copy of the plane, finds the first set flag, emits its row and column, and clears that flag. The next search then finds the following flag. This repeats until the working copy is empty.

Row selection works on a per-row OR reduction fed into a priority encoder. A second priority encoder then picks the first set column inside the chosen row. Both searches are combinational within one cycle, and the working copy updates on the clock edge. Encode time therefore scales with the number of flagged points, not with the number of pixels.

A client presents the whole plane in parallel and pulses `start`. It then collects coordinates while `pt_valid` is high and waits for `done`.

Top module: `multipoint_encoder`

## Requirements
- R1: After reset, `pt_valid` and `done` are both low.
- R2: After a cycle with `start` high and a plane holding N set flags, `pt_valid` is high for exactly N consecutive cycles. The first of these cycles is the cycle immediately after the `start` cycle, and each cycle carries one distinct flagged point.
- R3: Points come out in row-major priority order: lowest row index first, then lowest column index within a row.
- R4: The flag for row r and column c sits at bit r*COLS+c of `plane_in`. `pt_row` carries r and `pt_col` carries c as unsigned binary, 4 bits each for the default 15x15 plane.
- R5: `done` rises in the cycle right after the last point's valid cycle. It stays high with `pt_valid` low until the next `start`, and `start` clears it.
- R6: If the plane has no set flags, `done` is high in the cycle after the `start` cycle and `pt_valid` never rises.
- R7: A `start` during a scan discards the remaining points of the old plane. The next cycle begins emitting the new plane from its first point.
- R8: Changes on `plane_in` while `start` is low have no effect on the emitted points or on `done`.
- R9: The number of cycles a scan takes does not depend on where the flags sit. A single flag in the last row and column takes one cycle, and a fully set plane takes ROWS*COLS cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads `plane_in` and begins a new scan |
| plane_in | input | ROWS*COLS | Flag plane; bit r*COLS+c is row r, column c |
| pt_valid | output | 1 | A coordinate is present on `pt_row`/`pt_col` this cycle |
| pt_row | output | $clog2(ROWS) | Row index of the current point |
| pt_col | output | $clog2(COLS) | Column index of the current point |
| done | output | 1 | Scan finished; held until the next `start` |

## Verification
The bench targets several corner cases:
- An empty plane: a design that waited one scan cycle before noticing it would raise `done` a cycle late.
- A plane with several points in one row: a design that cleared a whole row, or cleared the wrong bit, would skip or repeat points.
- A restart in the middle of a scan: a design that kept the old mask or let the old scan finish would leak stale points.
- A lone flag in the far corner and a fully set plane: these expose an off-by-one in the last-bit clear and a done timing that is tied to plane size.
- A plane changed without `start`: a design that read `plane_in` directly instead of its own copy would change its output.

// File: rtl/mep_pkg.sv
package mep_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } mep_state_e;
endpackage

// File: rtl/mep_prio_enc.sv
// Lowest-index-wins priority encoder.
module mep_prio_enc #(
   parameter int N = 15,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx,
   output logic         any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = W'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/mep_row_or.sv
// One OR reduction per row of the flattened plane.
module mep_row_or #(
   parameter int ROWS = 15,
   parameter int COLS = 15
) (
   input  logic [ROWS*COLS-1:0] plane,
   output logic [ROWS-1:0]      row_any
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_any[r] = |plane[r*COLS +: COLS];
   end
endmodule

// File: rtl/mep_mask_clear.sv
// Clears the single selected flag from the working copy.
module mep_mask_clear #(
   parameter int ROWS = 15,
   parameter int COLS = 15,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic [ROWS*COLS-1:0] cur,
   input  logic [RW-1:0]        sel_row,
   input  logic [CW-1:0]        sel_col,
   output logic [ROWS*COLS-1:0] nxt
);
   for (genvar r = 0; r < ROWS; r++) begin : g_r
      for (genvar c = 0; c < COLS; c++) begin : g_c
         assign nxt[r*COLS+c] = cur[r*COLS+c] &
                                ~((sel_row == RW'(r)) && (sel_col == CW'(c)));
      end
   end
endmodule

// File: rtl/multipoint_encoder.sv
module multipoint_encoder
   import mep_pkg::*;
#(
   parameter int ROWS = 15,
   parameter int COLS = 15,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS),
   localparam int NPIX = ROWS * COLS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [NPIX-1:0] plane_in,
   output logic            pt_valid,
   output logic [RW-1:0]   pt_row,
   output logic [CW-1:0]   pt_col,
   output logic            done
);
   if (ROWS < 2 || COLS < 2) begin : g_bad_size
      $error("multipoint_encoder: ROWS and COLS must both be at least 2");
   end

   mep_state_e      state_q;
   logic [NPIX-1:0] mask_q;
   logic [NPIX-1:0] mask_nxt;
   logic [ROWS-1:0] row_any;
   logic [COLS-1:0] row_bits;
   logic [RW-1:0]   sel_row;
   logic [CW-1:0]   sel_col;
   logic            any_row;
   logic            any_col;

   mep_row_or #(.ROWS(ROWS), .COLS(COLS)) i_row_or (
      .plane   (mask_q),
      .row_any (row_any)
   );

   mep_prio_enc #(.N(ROWS)) i_row_enc (
      .vec (row_any),
      .idx (sel_row),
      .any (any_row)
   );

   always_comb begin
      row_bits = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (sel_row == RW'(r)) row_bits = mask_q[r*COLS +: COLS];
      end
   end

   mep_prio_enc #(.N(COLS)) i_col_enc (
      .vec (row_bits),
      .idx (sel_col),
      .any (any_col)
   );

   mep_mask_clear #(.ROWS(ROWS), .COLS(COLS)) i_clear (
      .cur     (mask_q),
      .sel_row (sel_row),
      .sel_col (sel_col),
      .nxt     (mask_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mask_q  <= '0;
      end else if (start) begin
         mask_q  <= plane_in;
         state_q <= (|plane_in) ? ST_SCAN : ST_DONE;
      end else if (state_q == ST_SCAN) begin
         mask_q <= mask_nxt;
         if (mask_nxt == '0) state_q <= ST_DONE;
      end
   end

   assign pt_valid = (state_q == ST_SCAN) && any_row && any_col;
   assign pt_row   = sel_row;
   assign pt_col   = sel_col;
   assign done     = (state_q == ST_DONE);
endmodule

// File: rtl/mep_checker.sv
module mep_checker #(
   parameter int ROWS = 15,
   parameter int COLS = 15,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 start,
   input logic [ROWS*COLS-1:0] plane_in,
   input logic                 pt_valid,
   input logic [RW-1:0]        pt_row,
   input logic [CW-1:0]        pt_col,
   input logic                 done
);
   // R5: valid and done never overlap
   a_r5_valid_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
      pt_valid |-> !done);

   // R4: coordinates stay within the plane
   a_r4_coord_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      pt_valid |-> (32'(pt_row) < ROWS) && (32'(pt_col) < COLS));

   // R5: done holds until a new start
   a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R6: empty plane finishes in one cycle
   a_r6_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
      (start && plane_in == '0) |=> (done && !pt_valid));

   // R2: a non-empty plane starts emitting in the next cycle
   a_r2_first_point: assert property (@(posedge clk) disable iff (!rst_n)
      (start && plane_in != '0) |=> pt_valid);

   // R3: consecutive points strictly increase in row-major order
   a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_valid && !start) |=> (!pt_valid ||
         (pt_row > $past(pt_row)) ||
         (pt_row == $past(pt_row) && pt_col > $past(pt_col))));
endmodule

bind multipoint_encoder mep_checker #(.ROWS(ROWS), .COLS(COLS)) i_mep_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .plane_in (plane_in),
   .pt_valid (pt_valid),
   .pt_row   (pt_row),
   .pt_col   (pt_col),
   .done     (done)
);

// File: tb/test_multipoint_encoder.sv
`timescale 1ns/1ps
module test_multipoint_encoder;
   localparam int ROWS = 15;
   localparam int COLS = 15;
   localparam int NPIX = ROWS * COLS;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [NPIX-1:0] plane_in = '0;
   logic            pt_valid;
   logic [3:0]      pt_row;
   logic [3:0]      pt_col;
   logic            done;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit finished = 1'b0;

   int exp_r[NPIX];
   int exp_c[NPIX];
   int exp_n;

   always #2.5 clk = ~clk;

   multipoint_encoder #(.ROWS(ROWS), .COLS(COLS)) i_multipoint_encoder (
      .clk(clk), .rst_n(rst_n), .start(start), .plane_in(plane_in),
      .pt_valid(pt_valid), .pt_row(pt_row), .pt_col(pt_col), .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void build_expect(input logic [NPIX-1:0] p);
      exp_n = 0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            if (p[r*COLS+c]) begin
               exp_r[exp_n] = r;
               exp_c[exp_n] = c;
               exp_n++;
            end
   endfunction

   // Drive start for one cycle; return at the negedge after the loading edge.
   task automatic kick(input logic [NPIX-1:0] p);
      @(negedge clk);
      plane_in = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Called at the negedge of the first scan cycle.
   task automatic expect_seq(input logic [NPIX-1:0] p, input string req);
      build_expect(p);
      for (int k = 0; k < exp_n; k++) begin
         check(pt_valid === 1'b1, {req, " valid"}, int'(pt_valid), 1);
         check(int'(pt_row) == exp_r[k], {req, " row"}, int'(pt_row), exp_r[k]);
         check(int'(pt_col) == exp_c[k], {req, " col"}, int'(pt_col), exp_c[k]);
         @(negedge clk);
      end
      check(done === 1'b1, {req, " R5 done after last"}, int'(done), 1);
      check(pt_valid === 1'b0, {req, " R5 valid low"}, int'(pt_valid), 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(pt_valid === 1'b0, "R1 reset valid", int'(pt_valid), 0);
      check(done === 1'b0, "R1 reset done", int'(done), 0);
   endtask

   task automatic t_empty;
      logic [NPIX-1:0] p = '0;
      kick(p);
      check(done === 1'b1, "R6 empty done", int'(done), 1);
      check(pt_valid === 1'b0, "R6 empty valid", int'(pt_valid), 0);
   endtask

   task automatic t_scatter;
      logic [NPIX-1:0] p = '0;
      p[0*COLS+3] = 1'b1; p[0*COLS+1] = 1'b1; p[4*COLS+14] = 1'b1;
      p[4*COLS+0] = 1'b1; p[9*COLS+7] = 1'b1; p[14*COLS+2] = 1'b1;
      kick(p);
      expect_seq(p, "R2 R3 R4 scatter");
   endtask

   task automatic t_one_row;
      logic [NPIX-1:0] p = '0;
      for (int c = 0; c < COLS; c += 2) p[6*COLS+c] = 1'b1;
      kick(p);
      expect_seq(p, "R3 one row");
   endtask

   task automatic t_diagonal;
      logic [NPIX-1:0] p = '0;
      for (int i = 0; i < ROWS; i++) p[i*COLS+(COLS-1-i)] = 1'b1;
      kick(p);
      expect_seq(p, "R4 diagonal");
   endtask

   task automatic t_corner;
      logic [NPIX-1:0] p = '0;
      p[NPIX-1] = 1'b1;
      kick(p);
      check(pt_valid === 1'b1 && pt_row == 4'd14 && pt_col == 4'd14,
            "R9 corner point", int'(pt_row)*100 + int'(pt_col), 1414);
      @(negedge clk);
      check(done === 1'b1, "R9 corner one cycle", int'(done), 1);
   endtask

   task automatic t_full;
      logic [NPIX-1:0] p = '1;
      kick(p);
      expect_seq(p, "R9 full plane");
   endtask

   task automatic t_restart;
      logic [NPIX-1:0] a = '0;
      logic [NPIX-1:0] b = '0;
      a[1*COLS+1] = 1'b1; a[2*COLS+2] = 1'b1; a[3*COLS+3] = 1'b1; a[5*COLS+5] = 1'b1;
      b[8*COLS+9] = 1'b1; b[12*COLS+0] = 1'b1;
      kick(a);
      check(pt_valid === 1'b1 && pt_row == 4'd1, "R7 old first point", int'(pt_row), 1);
      kick(b);
      expect_seq(b, "R7 restart");
   endtask

   task automatic t_ignore;
      logic [NPIX-1:0] p = '0;
      p[2*COLS+4] = 1'b1; p[10*COLS+11] = 1'b1;
      kick(p);
      plane_in = '1;
      expect_seq(p, "R8 plane change mid scan");
      plane_in = '0;
      repeat (3) @(negedge clk);
      check(done === 1'b1, "R8 done kept", int'(done), 1);
      check(pt_valid === 1'b0, "R8 no new points", int'(pt_valid), 0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      t_reset;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_empty;
      t_scatter;
      t_one_row;
      t_diagonal;
      t_corner;
      t_full;
      t_restart;
      t_ignore;
      t_empty;
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule